// File: doc/BRIEF.md
# Slice-Indirected Bitmap OSD Mixer

This block lays a two-bit-per-pixel bitmap overlay on top of a stream of active video pixels carried as 8-bit Y, U and V. The overlay artwork sits in a pool of 48 narrow tiles, called slices. Each slice is 8 pixels wide and 32 lines tall. A column table of 44 entries decides which slice appears in each 8-pixel column of a 352-pixel-wide window. Software can therefore rearrange the overlay, for example by swapping the digits of a clock display, by rewriting a few table entries and leaving the bitmap alone.

The block keeps its own pixel and line position. A frame pulse resets both. A line pulse starts a new line. Each pixel strobe moves one pixel to the right. For every strobed pixel the output is either a colour register value or the unchanged input pixel, and it appears one clock later. A host write port loads:
- the bitmap words,
- the column table,
- three colour registers,
- the window origin,
- a double-height enable.

The column table, the origin and the double-height enable are double buffered, so that a frame is never drawn with a half-updated layout.

Top module: `osd_slice_overlay`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_y`, `out_u` and `out_v` are 0. Every column-table entry reads as empty (63), the origin is (0,0), double height is off and the colour registers are 0.
- R2: `out_valid` follows `vid_valid` with exactly one clock of latency. The output pixel for a strobe is presented in that same cycle.
- R3: A `frame_start` pulse sets the position to line 0, pixel 0. A `line_start` pulse advances the line and sets the pixel to 0. Each `vid_valid` cycle uses the current position and then advances the pixel by one. The host does not raise pulses and strobes in the same cycle.
- R4: The window covers pixels X with OX <= X < OX+352 and lines Y with OY <= Y < OY+H, where H is 32 (or 64 in double height). Outside the window the output equals the input pixel.
- R5: Pixel p (0 = leftmost) of a bitmap word is held in bits [2p+1:2p]. Code 0 is transparent and passes the input pixel. Codes 1, 2 and 3 output colour register 1, 2 or 3 as {Y,U,V}.
- R6: Inside the window, column c = (X-OX)>>3 takes its slice number S from column-table entry c. It reads bitmap word S*32 + row, where row is the line offset within the window.
- R7: A column-table entry of 48 or above renders its whole column as transparent.
- R8: With double height on, row = (Y-OY)>>1, so each bitmap row is shown on two consecutive lines and the window is 64 lines tall.
- R9: Writes to the column table, the origin and the double-height enable take effect at the next `frame_start` and not before.
- R10: Writes to the bitmap and to the colour registers affect the very next pixel that uses them, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 bitmap, 1 column table, 2 colour, 3 control |
| wr_addr | input | 11 | Bitmap: {slice[10:5], row[4:0]}. Table: column index 0..43. Colour: 1..3. Control: 0 origin X, 1 origin Y, 2 double height |
| wr_data | input | 24 | Bitmap word [15:0], table entry [5:0], colour {Y,U,V}, control value |
| frame_start | input | 1 | Start-of-frame pulse |
| line_start | input | 1 | Start-of-line pulse |
| vid_valid | input | 1 | Active pixel strobe |
| vid_y | input | 8 | Input luma |
| vid_u | input | 8 | Input chroma U |
| vid_v | input | 8 | Input chroma V |
| out_valid | output | 1 | Output pixel strobe |
| out_y | output | 8 | Output luma |
| out_u | output | 8 | Output chroma U |
| out_v | output | 8 | Output chroma V |

## Verification
Every pixel result is due exactly one rising edge after the cycle in which its strobe is sampled. The driver drives each pixel on a falling edge, computes the expected colour from its own model of the bitmap, table, origin and colours, and queues it a moment later. The monitor pops one entry on the next falling edge whenever `out_valid` is high, and any mismatch in strobe count flags a latency error. Bitmap and colour writes are modelled as visible to the next pixel. Table and origin writes are held in a pending copy of the model that is committed only at the frame pulse.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int unsigned OSD_SLICES  = 48;
  localparam int unsigned OSD_SLICE_W = 8;
  localparam int unsigned OSD_SLICE_H = 32;
  localparam int unsigned OSD_COLS    = 44;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] u;
    logic [7:0] v;
  } yuv_t;

  typedef enum logic [1:0] {
    SEL_BITMAP = 2'd0,
    SEL_TABLE  = 2'd1,
    SEL_COLOUR = 2'd2,
    SEL_CTRL   = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/osd_bitmap_ram.sv
module osd_bitmap_ram #(
  parameter int unsigned SLICES = 48,
  parameter int unsigned ROWS   = 32,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 6,
  parameter int unsigned ROW_W  = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_slice,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [CODE_W-1:0] rd_slice,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_word
);
  localparam int unsigned DEPTH = SLICES * ROWS;
  localparam int unsigned ADR_W = $clog2(DEPTH) + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADR_W-1:0]  wa, ra;
  logic              wr_ok, rd_ok;

  always_comb begin
    wa    = ADR_W'(wr_slice) * ADR_W'(ROWS) + ADR_W'(wr_row);
    ra    = ADR_W'(rd_slice) * ADR_W'(ROWS) + ADR_W'(rd_row);
    wr_ok = wr_en && (wr_slice < CODE_W'(SLICES));
    rd_ok = rd_slice < CODE_W'(SLICES);
  end

  // storage array: no reset, written only by the host
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wa] <= wr_word;
  end

  assign rd_word = rd_ok ? mem[ra] : '0;
endmodule

// File: rtl/osd_slice_table.sv
module osd_slice_table #(
  parameter int unsigned COLS   = 44,
  parameter int unsigned CODE_W = 6,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              commit,
  input  logic [IDX_W-1:0]  rd_col,
  output logic [CODE_W-1:0] rd_code
);
  logic [COLS-1:0][CODE_W-1:0] pend_q, pend_d, act_q, act_d;
  logic [COLS-1:0]             hit;

  generate
    for (genvar i = 0; i < COLS; i++) begin : g_hit
      assign hit[i] = wr_en && (wr_idx == IDX_W'(i));
    end
  endgenerate

  always_comb begin
    pend_d = pend_q;
    for (int i = 0; i < COLS; i++) begin
      if (hit[i]) pend_d[i] = wr_code;
    end
    act_d = commit ? pend_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '1;
      act_q  <= '1;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign rd_code = (rd_col < IDX_W'(COLS)) ? act_q[rd_col] : '1;

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q)); // R9
endmodule

// File: rtl/osd_win_ctr.sv
module osd_win_ctr #(
  parameter int unsigned XW      = 11,
  parameter int unsigned YW      = 10,
  parameter int unsigned WIN_W   = 352,
  parameter int unsigned SLICE_H = 32,
  parameter int unsigned COL_W   = 6,
  parameter int unsigned ROW_W   = 5,
  parameter int unsigned PIX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic             vid_valid,
  input  logic [XW-1:0]    org_x,
  input  logic [YW-1:0]    org_y,
  input  logic             dbl,
  output logic             in_win,
  output logic [COL_W-1:0] col,
  output logic [PIX_W-1:0] pix,
  output logic [ROW_W-1:0] row
);
  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;
  logic [XW:0]   rx;
  logic [YW:0]   ry, h_lim;
  logic          in_x, in_y;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (frame_start) begin
      x_d = '0;
      y_d = '0;
    end else if (line_start) begin
      x_d = '0;
      if (y_q != '1) y_d = y_q + 1'b1;
    end else if (vid_valid && (x_q != '1)) begin
      x_d = x_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  always_comb begin
    rx     = {1'b0, x_q} - {1'b0, org_x};
    ry     = {1'b0, y_q} - {1'b0, org_y};
    h_lim  = dbl ? (YW+1)'(2 * SLICE_H) : (YW+1)'(SLICE_H);
    in_x   = (x_q >= org_x) && (rx < (XW+1)'(WIN_W));
    in_y   = (y_q >= org_y) && (ry < h_lim);
    in_win = in_x && in_y;
    col    = rx[PIX_W +: COL_W];
    pix    = rx[PIX_W-1:0];
    row    = dbl ? ry[1 +: ROW_W] : ry[ROW_W-1:0];
  end

  AST_X_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid && !frame_start && !line_start |=> x_q >= $past(x_q)); // R3
endmodule

// File: rtl/osd_slice_overlay.sv
module osd_slice_overlay
  import osd_pkg::*;
#(
  parameter int unsigned SLICES  = OSD_SLICES,
  parameter int unsigned SLICE_W = OSD_SLICE_W,
  parameter int unsigned SLICE_H = OSD_SLICE_H,
  parameter int unsigned COLS    = OSD_COLS,
  parameter int unsigned XW      = 11,
  parameter int unsigned YW      = 10,
  parameter int unsigned AW      = 11,
  parameter int unsigned DW      = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic          vid_valid,
  input  logic [7:0]    vid_y,
  input  logic [7:0]    vid_u,
  input  logic [7:0]    vid_v,
  output logic          out_valid,
  output logic [7:0]    out_y,
  output logic [7:0]    out_u,
  output logic [7:0]    out_v
);
  localparam int unsigned CODE_W = $clog2(SLICES);
  localparam int unsigned IDX_W  = $clog2(COLS);
  localparam int unsigned ROW_W  = $clog2(SLICE_H);
  localparam int unsigned PIX_W  = $clog2(SLICE_W);
  localparam int unsigned WORD_W = 2 * SLICE_W;
  localparam int unsigned WIN_W  = COLS * SLICE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // host write decode
  wr_sel_e sel;
  logic    bmp_we, tab_we;
  always_comb begin
    sel    = wr_sel_e'(wr_sel);
    bmp_we = wr_en && (sel == SEL_BITMAP);
    tab_we = wr_en && (sel == SEL_TABLE) && (wr_addr < AW'(COLS));
  end

  // control and colour registers
  logic [XW-1:0]   ox_p_q, ox_p_d, ox_a_q, ox_a_d;
  logic [YW-1:0]   oy_p_q, oy_p_d, oy_a_q, oy_a_d;
  logic            dbl_p_q, dbl_p_d, dbl_a_q, dbl_a_d;
  yuv_t [3:0]      col_q, col_d;

  always_comb begin
    ox_p_d  = ox_p_q;
    oy_p_d  = oy_p_q;
    dbl_p_d = dbl_p_q;
    col_d   = col_q;
    if (wr_en && (sel == SEL_CTRL)) begin
      if (wr_addr == AW'(0)) ox_p_d  = wr_data[XW-1:0];
      if (wr_addr == AW'(1)) oy_p_d  = wr_data[YW-1:0];
      if (wr_addr == AW'(2)) dbl_p_d = wr_data[0];
    end
    if (wr_en && (sel == SEL_COLOUR) && (wr_addr >= AW'(1)) && (wr_addr <= AW'(3)))
      col_d[wr_addr[1:0]] = wr_data;
    ox_a_d  = frame_start ? ox_p_q  : ox_a_q;
    oy_a_d  = frame_start ? oy_p_q  : oy_a_q;
    dbl_a_d = frame_start ? dbl_p_q : dbl_a_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ox_p_q <= '0; oy_p_q <= '0; dbl_p_q <= 1'b0;
      ox_a_q <= '0; oy_a_q <= '0; dbl_a_q <= 1'b0;
      col_q  <= '0;
    end else begin
      ox_p_q <= ox_p_d; oy_p_q <= oy_p_d; dbl_p_q <= dbl_p_d;
      ox_a_q <= ox_a_d; oy_a_q <= oy_a_d; dbl_a_q <= dbl_a_d;
      col_q  <= col_d;
    end
  end

  // position and window
  logic              in_win;
  logic [IDX_W-1:0]  col;
  logic [PIX_W-1:0]  pix;
  logic [ROW_W-1:0]  row;

  osd_win_ctr #(
    .XW(XW), .YW(YW), .WIN_W(WIN_W), .SLICE_H(SLICE_H),
    .COL_W(IDX_W), .ROW_W(ROW_W), .PIX_W(PIX_W)
  ) i_win (
    .clk(clk), .rst_n(rst_s), .frame_start(frame_start), .line_start(line_start),
    .vid_valid(vid_valid), .org_x(ox_a_q), .org_y(oy_a_q), .dbl(dbl_a_q),
    .in_win(in_win), .col(col), .pix(pix), .row(row)
  );

  logic [CODE_W-1:0] slice_code;

  osd_slice_table #(.COLS(COLS), .CODE_W(CODE_W), .IDX_W(IDX_W)) i_table (
    .clk(clk), .rst_n(rst_s), .wr_en(tab_we), .wr_idx(wr_addr[IDX_W-1:0]),
    .wr_code(wr_data[CODE_W-1:0]), .commit(frame_start),
    .rd_col(col), .rd_code(slice_code)
  );

  logic [WORD_W-1:0] rd_word;

  osd_bitmap_ram #(
    .SLICES(SLICES), .ROWS(SLICE_H), .WORD_W(WORD_W), .CODE_W(CODE_W), .ROW_W(ROW_W)
  ) i_bitmap (
    .clk(clk), .wr_en(bmp_we), .wr_slice(wr_addr[ROW_W +: CODE_W]),
    .wr_row(wr_addr[ROW_W-1:0]), .wr_word(wr_data[WORD_W-1:0]),
    .rd_slice(slice_code), .rd_row(row), .rd_word(rd_word)
  );

  // mixer and output register
  yuv_t       vid_in, mix, pix_q, pix_d;
  logic [1:0] pcode;
  logic       show, vld_q, vld_d;

  always_comb begin
    vid_in = {vid_y, vid_u, vid_v};
    pcode  = rd_word[{pix, 1'b0} +: 2];
    show   = in_win && (slice_code < CODE_W'(SLICES)) && (pcode != 2'b00);
    mix    = show ? col_q[pcode] : vid_in;
    vld_d  = vid_valid;
    pix_d  = vid_valid ? mix : pix_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vld_q <= 1'b0;
      pix_q <= '0;
    end else begin
      vld_q <= vld_d;
      pix_q <= pix_d;
    end
  end

  assign out_valid = vld_q;
  assign out_y     = pix_q.y;
  assign out_u     = pix_q.u;
  assign out_v     = pix_q.v;

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_s)
    vid_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_s)
    !vid_valid |=> !out_valid); // R2
  AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_s)
    vid_valid && !in_win |=> {out_y, out_u, out_v} == $past({vid_y, vid_u, vid_v})); // R4
  AST_EMPTY_COLUMN: assert property (@(posedge clk) disable iff (!rst_s)
    vid_valid && in_win && (slice_code >= CODE_W'(SLICES))
      |=> {out_y, out_u, out_v} == $past({vid_y, vid_u, vid_v})); // R7
endmodule

// File: tb/test_osd_slice_overlay.sv
module test_osd_slice_overlay;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [10:0] wr_addr;
  logic [23:0] wr_data;
  logic        frame_start, line_start, vid_valid;
  logic [7:0]  vid_y, vid_u, vid_v;
  logic        out_valid;
  logic [7:0]  out_y, out_u, out_v;

  always #2 clk = ~clk;

  osd_slice_overlay i_osd_slice_overlay (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_start(frame_start), .line_start(line_start),
    .vid_valid(vid_valid), .vid_y(vid_y), .vid_u(vid_u), .vid_v(vid_v),
    .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v)
  );

  typedef struct {
    logic [23:0] e;
    int          tag;
  } exp_t;

  exp_t q[$];
  int   tests = 0, fails = 0;
  int   bx = 0, by = 0, tag_ovr = 0;
  bit   mon_on = 1'b0;

  // reference model state
  logic [15:0] mbmp [48][32];
  int          tab_p [44], tab_a [44];
  int          ox_p = 0, oy_p = 0, ox_a = 0, oy_a = 0;
  bit          dbl_p = 0, dbl_a = 0;
  logic [23:0] mcol [4];

  function automatic string tname(int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10";
      default: return "R?";
    endcase
  endfunction

  function automatic void model(input int x, input int y, input logic [23:0] vin,
                                output logic [23:0] e, output int tag);
    int h, rx, ry, rw, s, p, code;
    h = dbl_a ? 64 : 32;
    if (x < ox_a || x >= ox_a + 352 || y < oy_a || y >= oy_a + h) begin
      e = vin; tag = 4; return;  // R4 outside
    end
    rx = x - ox_a; ry = y - oy_a;
    rw = dbl_a ? ry / 2 : ry;               // R8 row repeat
    s  = tab_a[rx / 8];                     // R6 indirection
    p  = rx % 8;
    if (s >= 48) begin e = vin; tag = 7; return; end  // R7 empty
    code = int'((mbmp[s][rw] >> (2 * p)) & 16'h3);
    if (code == 0) begin e = vin; tag = 5; end       // R5 transparent
    else begin e = mcol[code]; tag = dbl_a ? 8 : 6; end
  endfunction

  function automatic logic [15:0] pat(int s, int l);
    return 16'((s * 40503 + l * 2377 + 911) ^ (l << 9));
  endfunction

  task automatic clr_in();
    wr_en = 0; frame_start = 0; line_start = 0; vid_valid = 0;
  endtask

  task automatic hw(input int sel, input int addr, input int data);
    @(negedge clk);
    clr_in();
    wr_en = 1; wr_sel = 2'(sel); wr_addr = 11'(addr); wr_data = 24'(data);
    case (sel)
      0: if (addr / 32 < 48) mbmp[addr / 32][addr % 32] = 16'(data);
      1: if (addr < 44) tab_p[addr] = data & 63;
      2: if (addr >= 1 && addr <= 3) mcol[addr] = 24'(data);
      default: begin
        if (addr == 0) ox_p = data & 2047;
        if (addr == 1) oy_p = data & 1023;
        if (addr == 2) dbl_p = data[0];
      end
    endcase
  endtask

  task automatic frame();
    @(negedge clk);
    clr_in();
    frame_start = 1;
    for (int i = 0; i < 44; i++) tab_a[i] = tab_p[i];
    ox_a = ox_p; oy_a = oy_p; dbl_a = dbl_p;
    bx = 0; by = 0;
  endtask

  task automatic newline();
    @(negedge clk);
    clr_in();
    line_start = 1;
    by++; bx = 0;
  endtask

  task automatic pixel();
    logic [23:0] vin, e;
    int t;
    @(negedge clk);
    clr_in();
    vin = {8'(bx * 3 + by), 8'(bx ^ by), 8'(8'hA5 + bx)};
    vid_valid = 1; {vid_y, vid_u, vid_v} = vin;
    model(bx, by, vin, e, t);
    if (tag_ovr != 0) t = tag_ovr;
    #1 q.push_back('{e: e, tag: t});
    bx++;
  endtask

  task automatic run_line(input int n);
    for (int i = 0; i < n; i++) pixel();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr_in(); end
  endtask

  // scoreboard monitor: one expected item per output strobe
  always @(negedge clk) begin
    exp_t x;
    if (mon_on) begin
      if (out_valid) begin
        tests++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R2 output strobe: actual unexpected strobe expected none");
        end else begin
          x = q.pop_front();
          if ({out_y, out_u, out_v} !== x.e) begin
            fails++;
            $display("FAIL %s pixel: actual %h expected %h", tname(x.tag),
                     {out_y, out_u, out_v}, x.e);
          end
        end
      end else if (q.size() != 0) begin
        tests++; fails++;
        $display("FAIL R2 latency: actual no strobe expected %h", q[0].e);
        q.delete();
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual still running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 48; s++) for (int l = 0; l < 32; l++) mbmp[s][l] = '0;
    for (int i = 0; i < 44; i++) begin tab_p[i] = 63; tab_a[i] = 63; end
    for (int i = 0; i < 4; i++) mcol[i] = '0;
    clr_in(); wr_sel = 0; wr_addr = 0; wr_data = 0;
    vid_y = 0; vid_u = 0; vid_v = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset values at the outputs
    tests++;
    if (out_valid !== 1'b0 || {out_y, out_u, out_v} !== 24'h0) begin
      fails++;
      $display("FAIL R1 reset: actual %b/%h expected 0/000000", out_valid, {out_y, out_u, out_v});
    end
    mon_on = 1;

    // R1 R7: empty table after reset, window at origin passes video
    frame();
    for (int y = 0; y < 3; y++) begin if (y > 0) newline(); run_line(40); end
    idle(2);

    // load artwork and colours (R10 immediate), stage layout (R9)
    for (int l = 0; l < 32; l++) begin
      hw(0, 5 * 32 + l, int'(pat(5, l)));
      hw(0, 12 * 32 + l, int'(pat(12, l)));
      hw(0, 47 * 32 + l, int'(pat(47, l)));
    end
    hw(2, 1, 24'h10_80_80); hw(2, 2, 24'hEB_80_80); hw(2, 3, 24'h51_5A_F0);
    hw(1, 0, 5); hw(1, 1, 47); hw(1, 2, 63); hw(1, 3, 50); hw(1, 4, 12); hw(1, 43, 12);
    hw(3, 0, 4); hw(3, 1, 2); hw(3, 2, 0);
    // R9: staged table and origin must not act before the frame pulse
    tag_ovr = 9;
    newline(); run_line(60);
    tag_ovr = 0;
    idle(2);

    // R3 R4 R5 R6 R7: full frame, lines wider than the window right edge
    frame();
    for (int y = 0; y < 36; y++) begin if (y > 0) newline(); run_line(362); end
    idle(2);

    // R10: mid-frame colour and bitmap changes show on the next line
    frame();
    for (int y = 0; y < 3; y++) begin if (y > 0) newline(); run_line(48); end
    hw(2, 1, 24'h22_33_44);
    hw(0, 5 * 32 + 1, 16'h5555);
    hw(0, 5 * 32 + 3, 16'hFFFF);
    tag_ovr = 10;
    for (int y = 3; y < 6; y++) begin newline(); run_line(48); end
    // R9: table write mid-frame is held back until the next frame
    hw(1, 0, 12);
    tag_ovr = 9;
    for (int y = 6; y < 8; y++) begin newline(); run_line(48); end
    tag_ovr = 0;
    idle(2);

    // R8: double height, new origin, and the held table entry now active
    hw(3, 2, 1); hw(3, 1, 1); hw(3, 0, 0);
    frame();
    for (int y = 0; y < 68; y++) begin if (y > 0) newline(); run_line(48); end
    idle(4);

    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2 drain: actual %0d pending expected 0", q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule